// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

This block models a pipelined synchronous static memory whose data bus needs no idle cycle when traffic switches between reads and writes. Every rising clock edge can carry one command. A command is loaded when the advance/load input is low. On that edge the address, the read/write select, the four byte-lane enables and the three chip enables are all sampled. Read data leaves through a registered output one edge later. Write data follows its address by two edges, so reads and writes line up on the same pipeline slots and the bus can stay busy.

When advance/load is high, no new command is decoded. The previous command type carries on at the next address of a four-beat burst; the read/write select and the chip enables are not looked at. The 36-bit word is split into four 9-bit lanes, each holding 8 data bits and 1 parity bit. Lane x occupies bits [9x+8:9x] and is written only when its active-low enable is low on the write's address cycle. A write address passes through two stacked registers before the array is updated. A read issued on the edge right after a write to the same word sees the new lanes, forwarded straight from the data input.

Top module: `turnfree_sram`

## Requirements
- R1: While reset is held, and until the first read, `dout_en` is low. Reset is taken asynchronously and released on the second rising edge after `rst_n` rises.
- R2: A read is loaded on edge n when `adv_ld`=0, all chip enables are active and `wr_n`=1. `dout` holds the addressed word and `dout_en`=1 from edge n+1 until the next edge.
- R3: A write is loaded on edge n when `adv_ld`=0, all chip enables are active and `wr_n`=0. `din` sampled on edge n+2 is stored at that address, and `dout_en` is low after edge n+1.
- R4: Lane x (bits [9x+8:9x]) is written only if `bw_n[x]`=0 on the write's address edge. A lane whose enable is 1 keeps its stored value; `bw_n`=4'b0000 writes all 36 bits.
- R5: `ce_n` is active low. `ce_b` is active when it equals `pol_b`, and `ce_c` is active when it equals `pol_c`. A load with any enable inactive is a deselect: nothing is written and `dout_en`=0 after the next edge.
- R6: With `adv_ld`=1, `wr_n`, `ce_n`, `ce_b` and `ce_c` are ignored, and the cycle repeats the type of the previous cycle (read, write or deselect).
- R7: On burst cycles the upper address bits stay those of the loaded address. The two low bits step as (loaded + k) mod 4 on the k-th advance (linear order, the default variant).
- R8: A read loaded one edge after a write to the same address returns the write's `din` lanes for enabled lanes and the previously stored lanes elsewhere.
- R9: Reads and writes may alternate on consecutive edges with no idle cycle, and every read returns the value left by all writes loaded before it.
- R10: Deselect cycles that follow a write do not stop it: its data is still taken two edges after its address and stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W | Word address sampled on load cycles |
| adv_ld | input | 1 | 0 loads a new command, 1 advances the current burst |
| wr_n | input | 1 | 0 write, 1 read; only used on load cycles |
| bw_n | input | 4 | Active-low byte-lane write enables, lane x on bit x |
| ce_n | input | 1 | Primary chip enable, active low, sampled on load cycles |
| ce_b | input | 1 | Secondary chip enable, sense set by `pol_b` |
| ce_c | input | 1 | Tertiary chip enable, sense set by `pol_c` |
| pol_b | input | 1 | Static: 1 makes `ce_b` active high, 0 active low |
| pol_c | input | 1 | Static: 1 makes `ce_c` active high, 0 active low |
| din | input | 36 | Write data, taken two edges after its address |
| dout | output | 36 | Registered read data |
| dout_en | output | 1 | High when `dout` carries read data this cycle |

## Verification
Faults in the two write-address registers show up as corrupted lanes on a later read. A lost or misrouted pending write is visible as soon as the word is read back. A broken forwarding match appears on the very next cycle when a read directly follows a write to the same word. A wrong command-type or burst register shows at the ports one edge after the faulty cycle: `dout_en` goes high or low at the wrong time, or the burst reads the wrong word. The random stream interleaves bursts, partial-lane writes and deselects, so every stale lane meets a read within a few dozen cycles.

// File: rtl/turnfree_pkg.sv
package turnfree_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/turnfree_cmd.sv
module turnfree_cmd
  import turnfree_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int BURST_LINEAR = 1
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_ld,
  input  logic              wr_n,
  input  logic [LANES-1:0]  bw_n,
  input  logic              ce_n,
  input  logic              ce_b,
  input  logic              ce_c,
  input  logic              pol_b,
  input  logic              pol_c,
  output op_e               op_a,
  output logic [ADDR_W-1:0] addr_a,
  output logic [LANES-1:0]  be_a
);
  op_e               op_q, op_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [1:0]        cnt_q, cnt_d, cnt_step, low_nx;
  logic [LANES-1:0]  be_q, be_d;
  logic              sel_ok;

  assign sel_ok   = !ce_n && (ce_b == pol_b) && (ce_c == pol_c);
  assign cnt_step = cnt_q + 2'd1;

  generate
    if (BURST_LINEAR != 0) begin : g_linear
      assign low_nx = base_q[1:0] + cnt_step;
    end else begin : g_interleave
      assign low_nx = base_q[1:0] ^ cnt_step;
    end
  endgenerate

  always_comb begin
    be_d = ~bw_n;
    if (!adv_ld) begin
      op_d   = sel_ok ? (wr_n ? OP_RD : OP_WR) : OP_IDLE;
      addr_d = addr;
      base_d = addr;
      cnt_d  = 2'd0;
    end else begin
      op_d   = op_q;
      addr_d = {base_q[ADDR_W-1:2], low_nx};
      base_d = base_q;
      cnt_d  = cnt_step;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      base_q <= '0;
      cnt_q  <= 2'd0;
      be_q   <= '0;
    end else begin
      op_q   <= op_d;
      addr_q <= addr_d;
      base_q <= base_d;
      cnt_q  <= cnt_d;
      be_q   <= be_d;
    end
  end

  assign op_a   = op_q;
  assign addr_a = addr_q;
  assign be_a   = be_q;
endmodule

// File: rtl/turnfree_wq.sv
module turnfree_wq
  import turnfree_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  op_e               op_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [LANES-1:0]  be_a,
  output logic              b_wr,
  output logic [ADDR_W-1:0] b_addr,
  output logic [LANES-1:0]  b_be,
  output logic [LANES-1:0]  fwd_be
);
  logic              wr_d;
  logic              load_en;
  logic [ADDR_W-1:0] b_addr_q;
  logic [LANES-1:0]  b_be_q;
  logic              b_wr_q;

  assign wr_d    = (op_a == OP_WR);
  assign load_en = wr_d;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      b_wr_q <= 1'b0;
    end else begin
      b_wr_q <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      b_addr_q <= '0;
      b_be_q   <= '0;
    end else if (load_en) begin
      b_addr_q <= addr_a;
      b_be_q   <= be_a;
    end
  end

  assign b_wr   = b_wr_q;
  assign b_addr = b_addr_q;
  assign b_be   = b_be_q;
  assign fwd_be = (b_wr_q && (b_addr_q == addr_a)) ? b_be_q : '0;
endmodule

// File: rtl/turnfree_array.sv
module turnfree_array
  import turnfree_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [LANES-1:0]  wr_be,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] mem [DEPTH];
      logic              lane_we;

      assign lane_we = wr_en && wr_be[l];

      always_ff @(posedge clk) begin
        if (lane_we) begin
          mem[wr_addr] <= wr_data[l*LANE_W +: LANE_W];
        end
      end

      assign rd_data[l*LANE_W +: LANE_W] = mem[rd_addr];
    end
  endgenerate
endmodule

// File: rtl/turnfree_sram.sv
module turnfree_sram
  import turnfree_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int BURST_LINEAR = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_ld,
  input  logic              wr_n,
  input  logic [3:0]        bw_n,
  input  logic              ce_n,
  input  logic              ce_b,
  input  logic              ce_c,
  input  logic              pol_b,
  input  logic              pol_c,
  input  logic [35:0]       din,
  output logic [35:0]       dout,
  output logic              dout_en
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  op_e               op_a;
  logic [ADDR_W-1:0] addr_a;
  logic [LANES-1:0]  be_a;
  logic              b_wr;
  logic [ADDR_W-1:0] b_addr;
  logic [LANES-1:0]  b_be;
  logic [LANES-1:0]  fwd_be;
  logic [WORD_W-1:0] rd_data;
  logic [WORD_W-1:0] dout_d, dout_q;
  logic              dout_ce;
  logic              oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  turnfree_cmd #(.ADDR_W(ADDR_W), .BURST_LINEAR(BURST_LINEAR)) u_cmd (
    .clk(clk), .rst_sync_n(rst_sync_n), .addr(addr), .adv_ld(adv_ld),
    .wr_n(wr_n), .bw_n(bw_n), .ce_n(ce_n), .ce_b(ce_b), .ce_c(ce_c),
    .pol_b(pol_b), .pol_c(pol_c), .op_a(op_a), .addr_a(addr_a), .be_a(be_a)
  );

  turnfree_wq #(.ADDR_W(ADDR_W)) u_wq (
    .clk(clk), .rst_sync_n(rst_sync_n), .op_a(op_a), .addr_a(addr_a),
    .be_a(be_a), .b_wr(b_wr), .b_addr(b_addr), .b_be(b_be), .fwd_be(fwd_be)
  );

  turnfree_array #(.ADDR_W(ADDR_W)) u_array (
    .clk(clk), .wr_en(b_wr), .wr_addr(b_addr), .wr_be(b_be),
    .wr_data(din), .rd_addr(addr_a), .rd_data(rd_data)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_merge
      assign dout_d[l*LANE_W +: LANE_W] = fwd_be[l] ? din[l*LANE_W +: LANE_W]
                                                    : rd_data[l*LANE_W +: LANE_W];
    end
  endgenerate

  assign dout_ce = (op_a == OP_RD);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      oe_q <= 1'b0;
    end else begin
      oe_q <= dout_ce;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      dout_q <= '0;
    end else if (dout_ce) begin
      dout_q <= dout_d;
    end
  end

  assign dout    = dout_q;
  assign dout_en = oe_q;
endmodule

// File: rtl/turnfree_sram_chk.sv
module turnfree_sram_chk
  import turnfree_pkg::*;
#(
  parameter int ADDR_W       = 6,
  parameter int BURST_LINEAR = 1
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              adv_ld,
  input logic              wr_n,
  input logic              ce_n,
  input logic              ce_b,
  input logic              ce_c,
  input logic              pol_b,
  input logic              pol_c,
  input logic              dout_en,
  input logic              b_wr,
  input op_e               op_a,
  input logic [ADDR_W-1:0] addr_a
);
  logic sel_on;
  assign sel_on = !ce_n && (ce_b == pol_b) && (ce_c == pol_c);

  AST_READ_DRIVES_OUT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!adv_ld && sel_on && wr_n) |-> ##2 dout_en); // R2

  AST_WRITE_KEEPS_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!adv_ld && sel_on && !wr_n) |-> ##2 !dout_en); // R3

  AST_DESELECT_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!adv_ld && !sel_on) |-> ##2 !dout_en); // R5

  AST_ADVANCE_KEEPS_TYPE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    adv_ld |-> ##2 (dout_en == $past(dout_en))); // R6

  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((BURST_LINEAR != 0) && adv_ld) |=>
      ((addr_a[1:0] == $past(addr_a[1:0]) + 2'd1) &&
       (addr_a[ADDR_W-1:2] == $past(addr_a[ADDR_W-1:2])))); // R7

  AST_QUEUE_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    b_wr |-> $past(op_a == OP_WR)); // R3
endmodule

bind turnfree_sram turnfree_sram_chk #(.ADDR_W(ADDR_W), .BURST_LINEAR(BURST_LINEAR)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .adv_ld(adv_ld), .wr_n(wr_n),
  .ce_n(ce_n), .ce_b(ce_b), .ce_c(ce_c), .pol_b(pol_b), .pol_c(pol_c),
  .dout_en(dout_en), .b_wr(b_wr), .op_a(op_a), .addr_a(addr_a)
);

// File: tb/turnfree_sram_bench.sv
module turnfree_sram_bench;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          adv_ld = 1'b0;
  logic          wr_n = 1'b1;
  logic [3:0]    bw_n = 4'hF;
  logic          ce_n = 1'b1;
  logic          ce_b = 1'b1;
  logic          ce_c = 1'b0;
  logic          pol_b = 1'b1;
  logic          pol_c = 1'b0;
  logic [35:0]   din = '0;
  logic [35:0]   dout;
  logic          dout_en;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  logic [35:0] ref_mem [DEPTH];
  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_cnt = '0;
  int            m_last = 0;
  int            p1_op = 0, p2_op = 0;
  logic [AW-1:0] p1_addr = '0, p2_addr = '0;
  logic [3:0]    p1_be = '0, p2_be = '0;
  string         p1_tag = "R1";

  turnfree_sram #(.ADDR_W(AW)) u_turnfree_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .adv_ld(adv_ld), .wr_n(wr_n),
    .bw_n(bw_n), .ce_n(ce_n), .ce_b(ce_b), .ce_c(ce_c), .pol_b(pol_b),
    .pol_c(pol_c), .din(din), .dout(dout), .dout_en(dout_en)
  );

  always #4 clk = ~clk;

  task automatic check_bit(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout_en=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic check_word(input string tag, input logic [35:0] act, input logic [35:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: dout=%h expected %h", tag, act, exp);
    end
  endtask

  // One clock cycle: called and returns at a falling edge.
  task automatic cyc(input logic adv, input logic wr, input logic [AW-1:0] a,
                     input logic [3:0] bw, input logic cn, input logic cb,
                     input logic cc, input string tag);
    int            cur_op;
    logic [AW-1:0] cur_addr;
    if (!adv) begin
      cur_op   = (!cn && (cb == pol_b) && (cc == pol_c)) ? (wr ? 1 : 2) : 0;
      m_base   = a;
      m_cnt    = 2'd0;
      cur_addr = a;
    end else begin
      m_cnt    = m_cnt + 2'd1;
      cur_addr = {m_base[AW-1:2], m_base[1:0] + m_cnt};
      cur_op   = m_last;
    end
    m_last = cur_op;
    adv_ld = adv; wr_n = wr; addr = a; bw_n = bw;
    ce_n = cn; ce_b = cb; ce_c = cc;
    din[31:0]  = $urandom();
    din[35:32] = 4'($urandom());
    @(posedge clk);
    if (p2_op == 2) begin
      for (int l = 0; l < 4; l++)
        if (p2_be[l]) ref_mem[p2_addr][l*9 +: 9] = din[l*9 +: 9];
    end
    @(negedge clk);
    check_bit(p1_tag, dout_en, (p1_op == 1));
    if (p1_op == 1) check_word(p1_tag, dout, ref_mem[p1_addr]);
    p2_op = p1_op; p2_addr = p1_addr; p2_be = p1_be;
    p1_op = cur_op; p1_addr = cur_addr; p1_be = ~bw; p1_tag = tag;
  endtask

  task automatic idle(input string tag);
    cyc(1'b0, 1'b1, '0, 4'hF, 1'b1, pol_b, pol_c, tag);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [3:0] bw, input string tag);
    cyc(1'b0, 1'b0, a, bw, 1'b0, pol_b, pol_c, tag);
  endtask

  task automatic rd(input logic [AW-1:0] a, input string tag);
    cyc(1'b0, 1'b1, a, 4'hF, 1'b0, pol_b, pol_c, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    #1 rst_n = 1'b0;
    @(negedge clk);
    // R1: output disabled throughout reset
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check_bit("R1", dout_en, 1'b0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) idle("R1");

    // R3: fill the whole array with full-word writes
    for (int a = 0; a < DEPTH; a++) wr(6'(a), 4'h0, "R3");
    idle("R3"); idle("R3");

    // R2: plain read after the queue drains
    rd(6'd5, "R2"); idle("R2");
    rd(6'd63, "R2"); rd(6'd0, "R2"); idle("R2");

    // R8: read right after a partial write to the same word
    wr(6'd9, 4'b1010, "R8"); rd(6'd9, "R8"); idle("R8");
    wr(6'd10, 4'b0000, "R8"); rd(6'd10, "R8"); rd(6'd10, "R8"); idle("R8");

    // R4: no-lane write and single-lane write
    wr(6'd12, 4'hF, "R4"); idle("R4"); idle("R4"); rd(6'd12, "R4");
    wr(6'd12, 4'b0111, "R4"); idle("R4"); idle("R4"); rd(6'd12, "R4"); idle("R4");

    // R5: chip enable senses
    pol_b = 1'b0; pol_c = 1'b1;
    cyc(1'b0, 1'b0, 6'd20, 4'h0, 1'b0, 1'b1, 1'b1, "R5");
    cyc(1'b0, 1'b0, 6'd21, 4'h0, 1'b0, 1'b0, 1'b0, "R5");
    cyc(1'b0, 1'b0, 6'd22, 4'h0, 1'b1, 1'b0, 1'b1, "R5");
    cyc(1'b0, 1'b1, 6'd20, 4'hF, 1'b0, 1'b1, 1'b1, "R5");
    idle("R5"); idle("R5");
    rd(6'd20, "R5"); rd(6'd21, "R5"); rd(6'd22, "R5"); idle("R5");
    pol_b = 1'b1; pol_c = 1'b0;

    // R6 and R7: burst read with wr_n low and ce_n high on advance cycles
    rd(6'd6, "R7");
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 6'd33, 4'h0, 1'b1, 1'b0, 1'b1, "R6");
    idle("R7");
    // burst write from 34, then burst read back from 32
    wr(6'd34, 4'h0, "R7");
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 6'd1, 4'h0, 1'b1, 1'b0, 1'b1, "R6");
    rd(6'd32, "R7");
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b0, 6'd2, 4'h0, 1'b0, 1'b1, 1'b0, "R7");
    // deselect burst stays deselected
    idle("R6");
    for (int k = 0; k < 3; k++) cyc(1'b1, 1'b1, 6'd3, 4'hF, 1'b0, 1'b1, 1'b0, "R6");

    // R10: write followed by deselects still lands
    wr(6'd40, 4'b0100, "R10"); idle("R10"); idle("R10"); idle("R10");
    rd(6'd40, "R10"); idle("R10");

    // R9: strict read/write alternation
    for (int i = 0; i < 40; i++) begin
      logic [AW-1:0] ra = 6'($urandom() % 8);
      if (i % 2 == 0) wr(ra, 4'($urandom()), "R9");
      else rd(ra, "R9");
    end

    // R9: constrained random mix, two chip-enable polarity settings
    for (int seg = 0; seg < 2; seg++) begin
      pol_b = seg[0]; pol_c = ~seg[0];
      for (int i = 0; i < 600; i++) begin
        int r = int'($urandom() % 16);
        logic adv = (r < 4);
        logic cn = ($urandom() % 8 == 0);
        logic [3:0] bw = ($urandom() % 2 == 0) ? 4'h0 : 4'($urandom());
        cyc(adv, 1'($urandom()), 6'($urandom() % 16), bw, cn, pol_b, pol_c, "R9");
      end
    end
    idle("R9"); idle("R9"); idle("R9");
    finish_run();
  end
endmodule